// File: doc/BRIEF.md
# Relocatable I/O Window Decoder

This block places a 16-byte window of control bytes in the processor I/O space, at a base that software can move. Software reaches a 64-bit model-specific control register through a read/write port. The register holds the window base, an enable bit and a bit that requests special bus cycles. Every processor I/O access is compared against the window in the same cycle. An access that hits the window reads or writes a 16-byte backing store. This store stands in for the control bytes that other logic would act on.

When special cycles are requested, a doubleword access that lands in the enabled window also starts a one-clock special bus cycle on the next clock. That cycle drives a fixed active-low byte-enable pattern and a fixed value on address bits 4:3. Turning the window off only hides the store from access. It never clears or changes the store, so turning the window back on shows the same bytes as before.

Top module: `iowin_decoder`

## Requirements
- R1: After reset the control register reads as all zeros: the window is disabled, its base is 0 and special cycles are off. An access to I/O address 0 then does not hit, and spc_req is 0.
- R2: A control register write takes bits 15:4 (base), bit 1 (special-cycle request) and bit 0 (enable). msr_rdata returns these fields in the same positions. Bits 63:16 and 3:2 always read 0, whatever value was written to them.
- R3: io_hit is 1 in the same cycle exactly when io_valid=1, enable=1 and io_addr[15:4] equals the base. An access in the same cycle as a control register write is decoded with the register values from before that write.
- R4: A write hit stores io_wdata byte k at window offset (io_addr[3:0]+k) mod 16, for k below the access width. io_size 0 is a byte, 1 is a word, and 2 or 3 is a doubleword.
- R5: A read hit returns window byte (io_addr[3:0]+k) mod 16 in io_rdata bits 8k+7:8k, with the unused upper bytes at 0. io_rdata is 0 whenever the access is not a read hit.
- R6: Accesses that miss the window, or that arrive while it is disabled, leave the backing store unchanged.
- R7: Clearing the enable bit keeps the store contents. Setting it again returns the same bytes.
- R8: A doubleword hit while the special-cycle bit is 1 makes spc_req 1 for exactly the following clock, with spc_be_n=8'hBF and spc_addr43=2'b00. When spc_req is 0, spc_be_n is 8'hFF.
- R9: Byte and word hits never raise spc_req, even with the special-cycle bit set. No hit raises it while the special-cycle bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msr_wr | input | 1 | Control register write strobe |
| msr_wdata | input | 64 | Control register write data |
| msr_rdata | output | 64 | Control register read value |
| io_valid | input | 1 | Processor I/O access present this cycle |
| io_addr | input | 16 | I/O address |
| io_size | input | 2 | 0 byte, 1 word, 2 or 3 doubleword |
| io_write | input | 1 | 1 write, 0 read |
| io_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| io_hit | output | 1 | Access falls in the enabled window |
| io_rdata | output | 32 | Read data on a read hit, else 0 |
| spc_req | output | 1 | Special bus cycle pulse |
| spc_be_n | output | 8 | Active-low byte enables of the special cycle |
| spc_addr43 | output | 2 | Address bits 4:3 of the special cycle |

## Verification
The hardest case to reach is an access whose offset plus its width runs past the end of the window. Such an access must wrap around to the start of the same store. A second hard case is an access that arrives in the same clock as a control register write that moves or disables the window. The directed stimulus places a doubleword write at offset 14 and a word read at offset 15. It also issues a relocating register write and a doubleword read in one cycle. A random phase then moves the base among a few values near the addresses it generates, and a behavioural model checks every clock.

// File: rtl/iowin_decoder.sv
module iowin_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        msr_wr,
  input  logic [63:0] msr_wdata,
  output logic [63:0] msr_rdata,
  input  logic        io_valid,
  input  logic [15:0] io_addr,
  input  logic [1:0]  io_size,
  input  logic        io_write,
  input  logic [31:0] io_wdata,
  output logic        io_hit,
  output logic [31:0] io_rdata,
  output logic        spc_req,
  output logic [7:0]  spc_be_n,
  output logic [1:0]  spc_addr43
);
  localparam int WIN_BYTES = 16;
  localparam int MAX_BYTES = 4;

  logic [11:0] base_q;
  logic        en_q;
  logic        gsbc_q;
  logic        spc_q;
  logic [7:0]  store [WIN_BYTES];
  logic [2:0]  nbytes;
  logic [3:0]  off;
  logic        dword;

  wire unused_resv = ^{msr_wdata[63:16], msr_wdata[3:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      en_q   <= 1'b0;
      gsbc_q <= 1'b0;
    end else if (msr_wr) begin
      base_q <= msr_wdata[15:4];
      gsbc_q <= msr_wdata[1];
      en_q   <= msr_wdata[0];
    end
  end

  assign msr_rdata = {48'd0, base_q, 2'b00, gsbc_q, en_q};

  assign off    = io_addr[3:0];
  assign dword  = io_size[1];
  assign nbytes = dword ? 3'd4 : (io_size[0] ? 3'd2 : 3'd1);
  assign io_hit = io_valid && en_q && (io_addr[15:4] == base_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN_BYTES; i++) store[i] <= 8'd0;
    end else if (io_hit && io_write) begin
      for (int k = 0; k < MAX_BYTES; k++)
        if (k < int'(nbytes)) store[4'(int'(off) + k)] <= io_wdata[8*k +: 8];
    end
  end

  always_comb begin
    io_rdata = '0;
    if (io_hit && !io_write)
      for (int k = 0; k < MAX_BYTES; k++)
        if (k < int'(nbytes)) io_rdata[8*k +: 8] = store[4'(int'(off) + k)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spc_q <= 1'b0;
    else        spc_q <= io_hit && dword && gsbc_q;
  end

  assign spc_req    = spc_q;
  assign spc_be_n   = spc_q ? 8'hBF : 8'hFF;
  assign spc_addr43 = 2'b00;
endmodule

// File: rtl/iowin_decoder_chk.sv
module iowin_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] msr_rdata,
  input logic        io_valid,
  input logic [15:0] io_addr,
  input logic [1:0]  io_size,
  input logic        io_hit,
  input logic [31:0] io_rdata,
  input logic        spc_req,
  input logic [7:0]  spc_be_n,
  input logic [1:0]  spc_addr43
);
  AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    msr_rdata[63:16] == 48'd0 && msr_rdata[3:2] == 2'b00); // R2
  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !msr_rdata[0] |-> !io_hit); // R3
  AST_HIT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> io_valid && io_addr[15:4] == msr_rdata[15:4]); // R3
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !io_hit |-> io_rdata == 32'd0); // R5
  AST_SPC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    spc_req |-> $past(io_hit && io_size[1] && msr_rdata[1])); // R8
  AST_SPC_ENCODE: assert property (@(posedge clk) disable iff (!rst_n)
    spc_req |-> spc_be_n == 8'hBF && spc_addr43 == 2'b00); // R8
  AST_SPC_IDLE_BE: assert property (@(posedge clk) disable iff (!rst_n)
    !spc_req |-> spc_be_n == 8'hFF); // R8
  AST_SPC_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit && !io_size[1] |=> !spc_req); // R9
endmodule

bind iowin_decoder iowin_decoder_chk chk_i (.*);

// File: tb/iowin_decoder_tb_top.sv
module iowin_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msr_wr = 1'b0;
  logic [63:0] msr_wdata = '0;
  logic [63:0] msr_rdata;
  logic        io_valid = 1'b0;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_size = '0;
  logic        io_write = 1'b0;
  logic [31:0] io_wdata = '0;
  logic        io_hit;
  logic [31:0] io_rdata;
  logic        spc_req;
  logic [7:0]  spc_be_n;
  logic [1:0]  spc_addr43;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  iowin_decoder dut_i (.*);

  logic [7:0]  m_store [16];
  logic [11:0] m_base;
  logic        m_en, m_gs, m_spc;
  logic        p_val, p_msr, p_wr, p_spc;
  logic [63:0] p_msrd;
  logic [3:0]  p_off;
  int          p_nb;
  logic [31:0] p_wd;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic hit;
      logic [31:0] rd;
      int nb;
      nb = io_size[1] ? 4 : (io_size[0] ? 2 : 1);
      hit = io_valid && m_en && (io_addr[15:4] == m_base);
      rd = '0;
      if (hit && !io_write)
        for (int k = 0; k < nb; k++) rd[8*k +: 8] = m_store[(io_addr[3:0] + k) % 16];
      check("R2 msr_rdata", msr_rdata, {48'd0, m_base, 2'b00, m_gs, m_en});
      check("R3 io_hit", {63'd0, io_hit}, {63'd0, hit});
      check("R5 io_rdata", {32'd0, io_rdata}, {32'd0, rd});
      check("R8 spc_req", {63'd0, spc_req}, {63'd0, m_spc});
      check("R8 spc_be_n", {56'd0, spc_be_n}, {56'd0, m_spc ? 8'hBF : 8'hFF});
      check("R8 spc_addr43", {62'd0, spc_addr43}, 64'd0);
      p_val = 1'b1;
      p_msr = msr_wr; p_msrd = msr_wdata;
      p_wr = hit && io_write; p_off = io_addr[3:0]; p_nb = nb; p_wd = io_wdata;
      p_spc = hit && (nb == 4) && m_gs;
    end else p_val = 1'b0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_store[i] = 8'd0;
      m_base = '0; m_en = 1'b0; m_gs = 1'b0; m_spc = 1'b0;
    end else if (p_val) begin
      if (p_wr)
        for (int k = 0; k < p_nb; k++) m_store[(p_off + k) % 16] = p_wd[8*k +: 8];
      if (p_msr) begin
        m_base = p_msrd[15:4]; m_gs = p_msrd[1]; m_en = p_msrd[0];
      end
      m_spc = p_spc;
    end
  end

  task automatic drive_io(input logic [15:0] a, input logic [1:0] s, input logic w, input logic [31:0] d);
    @(posedge clk); #2;
    msr_wr = 1'b0; io_valid = 1'b1; io_addr = a; io_size = s; io_write = w; io_wdata = d;
  endtask

  task automatic drive_msr(input logic [63:0] d);
    @(posedge clk); #2;
    msr_wr = 1'b1; msr_wdata = d; io_valid = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); #2;
    msr_wr = 1'b0; io_valid = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [15:0] a, input logic [1:0] s,
                          input logic hit_e, input logic [31:0] exp);
    drive_io(a, s, 1'b0, '0);
    @(negedge clk);
    check(tag, {63'd0, io_hit}, {63'd0, hit_e});
    check(tag, {32'd0, io_rdata}, {32'd0, exp});
  endtask

  initial begin
    #(200000 * 8);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    io_valid = 1'b1; io_addr = 16'h0000; io_size = 2'd2;
    repeat (3) @(posedge clk);
    #1;
    check("R1 msr_rdata reset", msr_rdata, 64'd0);
    check("R1 spc_req reset", {63'd0, spc_req}, 64'd0);
    @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk);
    check("R1 no hit at base 0", {63'd0, io_hit}, 64'd0);

    drive_msr(64'hFFFF_FFFF_FFFF_123F);
    idle(); @(negedge clk);
    check("R2 reserved dropped", msr_rdata, 64'h1233);
    drive_msr(64'h1231);
    drive_io(16'h1230, 2'd2, 1'b1, 32'h0302_0100);
    drive_io(16'h1234, 2'd2, 1'b1, 32'h0706_0504);
    drive_io(16'h1238, 2'd2, 1'b1, 32'h0B0A_0908);
    drive_io(16'h123C, 2'd2, 1'b1, 32'h0F0E_0D0C);
    rd_check("R5 dword read", 16'h1232, 2'd2, 1'b1, 32'h0504_0302);
    rd_check("R5 word wrap", 16'h123F, 2'd1, 1'b1, 32'h0000_000F);
    drive_io(16'h1235, 2'd0, 1'b1, 32'hFFFF_FFAA);
    rd_check("R4 byte write", 16'h1234, 2'd2, 1'b1, 32'h0706_AA04);
    drive_io(16'h123E, 2'd3, 1'b1, 32'hDDCC_BBAA);
    rd_check("R4 dword wrap", 16'h1230, 2'd1, 1'b1, 32'h0000_DDCC);
    drive_io(16'h1240, 2'd2, 1'b1, 32'hFFFF_FFFF);
    rd_check("R3 miss next block", 16'h1240, 2'd2, 1'b0, 32'h0);
    rd_check("R6 miss write ignored", 16'h1230, 2'd2, 1'b1, 32'h0302_DDCC);
    drive_msr(64'h1230);
    rd_check("R3 disabled no hit", 16'h1230, 2'd2, 1'b0, 32'h0);
    drive_io(16'h1230, 2'd2, 1'b1, 32'h1111_1111);
    drive_msr(64'h1231);
    rd_check("R7 reenable keeps store", 16'h1230, 2'd2, 1'b1, 32'h0302_DDCC);
    drive_msr(64'h1233);
    drive_io(16'h1234, 2'd2, 1'b0, '0);
    idle(); @(negedge clk);
    check("R8 spc pulse", {63'd0, spc_req}, 64'd1);
    check("R8 spc be_n", {56'd0, spc_be_n}, 64'hBF);
    idle(); @(negedge clk);
    check("R8 spc single clock", {63'd0, spc_req}, 64'd0);
    drive_io(16'h1236, 2'd1, 1'b1, 32'h0000_5566);
    idle(); @(negedge clk);
    check("R9 word no spc", {63'd0, spc_req}, 64'd0);
    drive_msr(64'h1231);
    drive_io(16'h1230, 2'd2, 1'b0, '0);
    idle(); @(negedge clk);
    check("R9 gsbc off no spc", {63'd0, spc_req}, 64'd0);
    drive_msr(64'hABC3);
    rd_check("R3 old base misses", 16'h1230, 2'd2, 1'b0, 32'h0);
    rd_check("R3 relocated hit", 16'hABC0, 2'd2, 1'b1, 32'h0302_DDCC);
    @(posedge clk); #2;
    msr_wr = 1'b1; msr_wdata = 64'h0001;
    io_valid = 1'b1; io_addr = 16'hABC4; io_size = 2'd2; io_write = 1'b0;
    @(negedge clk);
    check("R3 same-cycle old base", {63'd0, io_hit}, 64'd1);
    idle(); @(negedge clk);
    check("R8 same-cycle spc", {63'd0, spc_req}, 64'd1);

    for (int n = 0; n < 600; n++) begin
      @(posedge clk); #2;
      if ($urandom_range(0, 9) == 0) begin
        logic [11:0] b;
        b = ($urandom_range(0, 1) == 0) ? 12'h123 : 12'h124;
        msr_wr = 1'b1;
        msr_wdata = {$urandom, $urandom};
        msr_wdata[15:4] = b;
        msr_wdata[0] = ($urandom_range(0, 3) != 0);
      end else msr_wr = 1'b0;
      io_valid = ($urandom_range(0, 4) != 0);
      io_addr  = {($urandom_range(0, 1) == 0) ? 12'h123 : 12'h124, 4'($urandom_range(0, 15))};
      io_size  = 2'($urandom_range(0, 3));
      io_write = $urandom_range(0, 1) == 1;
      io_wdata = $urandom;
    end
    idle(); idle(); @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule